// File: doc/BRIEF.md
# I2C Master Target Address Control

This block keeps the address settings that an I2C master controller applies to the transfers it starts next. Software reaches those settings through a 32-bit register port. Each write is checked against the live state of the controller. A write that fails the check is discarded and marked with a one-cycle pulse. The stored fields choose one of four address-phase forms: normal 7-bit, normal 10-bit, general call or START byte. From that form and the direction of the command at the head of the queue, the block produces the first address byte, and for 10-bit mode also the second byte.

The block also watches the command queue. While general-call mode is active, a read command is not passed on. Instead it sets a sticky transmit-abort flag, which stays set until a dedicated clear pulse arrives. A compile-time parameter selects the write rule. With dynamic update off, writes land only while the controller is disabled and the 10-bit select bit is not stored. With dynamic update on, writes are also accepted while the controller is enabled, provided the master is idle and able to take new settings.

Top module: `i2c_tgt_addr_ctrl`

## Requirements
- R1: After reset the register reads 0x0000_1055: target address 0x055 in bits 9:0, 10-bit select (bit 12) = 1, special enable (bit 11) = 0, call/start select (bit 10) = 0.
- R2: Bits 31:13 of the read data are always 0, whatever value was written to them.
- R3: A write while `ctl_enabled` = 0 is accepted, and the new field values can be read on the cycle after the write strobe.
- R4: With dynamic update on and `ctl_enabled` = 1, a write is accepted only when `mst_busy` = 0, `mst_mode` = 1 and `txf_empty` = 1. Otherwise it is dropped.
- R5: A dropped write leaves every field unchanged and raises `wr_rejected` for exactly the one cycle after the write strobe.
- R6: `addr_mode` encodes the form as 0 = 7-bit, 1 = 10-bit, 2 = general call, 3 = START byte. With bit 11 = 0, bit 10 is ignored and bit 12 selects 0 or 1. In 7-bit mode `first_byte` = {addr[6:0], rd}, where rd = 1 for a read, and `second_byte` = 0.
- R7: In 10-bit mode `first_byte` = {5'b11110, addr[9:8], rd} and `second_byte` = addr[7:0].
- R8: With bit 11 = 1 and bit 10 = 0 the mode is general call: `first_byte` = 0x00 whatever the address is, and write commands are forwarded.
- R9: With bit 11 = 1 and bit 10 = 1 the mode is START byte: `first_byte` = 0x01.
- R10: In general-call mode a valid read command is not forwarded (`cmd_fwd` = 0), and `tx_abort` is 1 from the next cycle on. It stays set until it is cleared.
- R11: A pulse on `abort_clr` clears `tx_abort` on the next cycle. If a new abort condition occurs in the same cycle, the set takes priority. General-call mode itself ends only when software writes bit 11 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Current register contents |
| ctl_enabled | input | 1 | Controller is enabled |
| mst_mode | input | 1 | Controller is configured as master |
| mst_busy | input | 1 | A master transfer is in progress |
| txf_empty | input | 1 | Transmit queue is empty |
| wr_rejected | output | 1 | One-cycle pulse after a dropped write |
| cmd_valid | input | 1 | A command is waiting at the queue head |
| cmd_is_read | input | 1 | The waiting command is a read |
| abort_clr | input | 1 | Single-cycle clear of the abort flag |
| cmd_fwd | output | 1 | The waiting command is passed on |
| tx_abort | output | 1 | Sticky transmit-abort flag |
| addr_mode | output | 2 | Address-phase form (encoding in R6) |
| first_byte | output | 8 | First address byte |
| second_byte | output | 8 | Second address byte (10-bit mode only) |

## Verification
The write gate is driven through all eight combinations of busy, master-mode and queue-empty with the controller enabled, and once with it disabled. This shows whether a single missing term in the qualification rule lets a write through or blocks it. Writes with the high bits set and with address values whose upper bits differ from their lower bits show whether reserved bits leak into the register and whether the 7-bit and 10-bit byte formats take the correct address slices. Read and write commands are issued in each of the four modes, with abort clears at varied times, including in the same cycle as a new abort. These show whether the read blocking, the sticky flag and the set-over-clear priority are tied to general call alone. A long run of random writes, status values and commands is compared on every clock against a behavioural model.

// File: rtl/i2c_tac_pkg.sv
package i2c_tac_pkg;

  localparam int TAR_W = 10;

  typedef enum logic [1:0] {
    AM_7BIT   = 2'd0,
    AM_10BIT  = 2'd1,
    AM_GCALL  = 2'd2,
    AM_STBYTE = 2'd3
  } amode_t;

  typedef struct packed {
    logic             m10;
    logic             spec;
    logic             sel;
    logic [TAR_W-1:0] tar;
  } tgt_cfg_t;

  localparam int CFG_W = $bits(tgt_cfg_t);

  function automatic amode_t pick_mode(tgt_cfg_t c);
    if (c.spec) return c.sel ? AM_STBYTE : AM_GCALL;
    return c.m10 ? AM_10BIT : AM_7BIT;
  endfunction

  function automatic logic [7:0] lead_byte(amode_t m, logic [TAR_W-1:0] a, logic rd);
    case (m)
      AM_7BIT:  return {a[6:0], rd};
      AM_10BIT: return {5'b11110, a[9:8], rd};
      AM_GCALL: return 8'h00;
      default:  return 8'h01;
    endcase
  endfunction

  function automatic logic [7:0] tail_byte(amode_t m, logic [TAR_W-1:0] a);
    return (m == AM_10BIT) ? a[7:0] : 8'h00;
  endfunction

endpackage

// File: rtl/i2c_tac_wr_gate.sv
module i2c_tac_wr_gate #(
  parameter bit DYN_UPDATE = 1'b1
) (
  input  logic wr_en,
  input  logic ctl_enabled,
  input  logic mst_mode,
  input  logic mst_busy,
  input  logic txf_empty,
  output logic wr_accept,
  output logic wr_drop
);

  logic live_ok;

  generate
    if (DYN_UPDATE) begin : g_dyn
      assign live_ok = !mst_busy && mst_mode && txf_empty;
    end else begin : g_static
      assign live_ok = 1'b0;
    end
  endgenerate

  assign wr_accept = wr_en && (!ctl_enabled || live_ok);
  assign wr_drop   = wr_en && !wr_accept;

endmodule

// File: rtl/i2c_tac_regs.sv
module i2c_tac_regs
  import i2c_tac_pkg::*;
#(
  parameter bit               DYN_UPDATE = 1'b1,
  parameter logic [TAR_W-1:0] RST_TAR    = 10'h055,
  parameter bit               RST_M10    = 1'b1,
  parameter int               REG_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_accept,
  input  logic             wr_drop,
  input  logic [CFG_W-1:0] wr_data,
  output tgt_cfg_t         cfg,
  output logic [REG_W-1:0] rd_data,
  output logic             wr_rejected
);

  localparam int PAD_W = REG_W - CFG_W;

  tgt_cfg_t cfg_q;
  tgt_cfg_t cfg_d;
  logic     m10_rd;

  assign cfg_d = tgt_cfg_t'(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.spec  <= 1'b0;
      cfg_q.sel   <= 1'b0;
      cfg_q.tar   <= RST_TAR;
      wr_rejected <= 1'b0;
    end else begin
      wr_rejected <= wr_drop;
      if (wr_accept) begin
        cfg_q.spec <= cfg_d.spec;
        cfg_q.sel  <= cfg_d.sel;
        cfg_q.tar  <= cfg_d.tar;
      end
    end
  end

  generate
    if (DYN_UPDATE) begin : g_m10_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cfg_q.m10 <= RST_M10;
        else if (wr_accept) cfg_q.m10 <= cfg_d.m10;
      end
      assign m10_rd = cfg_q.m10;
    end else begin : g_m10_fixed
      assign cfg_q.m10 = RST_M10;
      assign m10_rd    = 1'b0;
    end
  endgenerate

  assign cfg     = cfg_q;
  assign rd_data = {{PAD_W{1'b0}}, m10_rd, cfg_q.spec, cfg_q.sel, cfg_q.tar};

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_accept) |-> $stable(cfg_q));  // R5
  AST_REJ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rejected |-> $past(wr_drop));  // R5

endmodule

// File: rtl/i2c_tac_addr_phase.sv
module i2c_tac_addr_phase
  import i2c_tac_pkg::*;
(
  input  tgt_cfg_t   cfg,
  input  logic       cmd_is_read,
  output amode_t     mode,
  output logic [7:0] b_first,
  output logic [7:0] b_second
);

  always_comb begin
    mode     = pick_mode(cfg);
    b_first  = lead_byte(mode, cfg.tar, cmd_is_read);
    b_second = tail_byte(mode, cfg.tar);
  end

endmodule

// File: rtl/i2c_tac_abort.sv
module i2c_tac_abort (
  input  logic clk,
  input  logic rst_n,
  input  logic gc_mode,
  input  logic cmd_valid,
  input  logic cmd_is_read,
  input  logic abort_clr,
  output logic cmd_fwd,
  output logic tx_abort
);

  logic gc_read_hit;

  assign gc_read_hit = gc_mode && cmd_valid && cmd_is_read;
  assign cmd_fwd     = cmd_valid && !(gc_mode && cmd_is_read);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           tx_abort <= 1'b0;
    else if (gc_read_hit) tx_abort <= 1'b1;
    else if (abort_clr)   tx_abort <= 1'b0;
  end

  AST_GC_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (gc_mode && cmd_is_read) |-> !cmd_fwd);  // R10
  AST_ABORT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    gc_read_hit |=> tx_abort);  // R10
  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_abort && !abort_clr) |=> tx_abort);  // R10
  AST_ABORT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_clr && !gc_read_hit) |=> !tx_abort);  // R11

endmodule

// File: rtl/i2c_tgt_addr_ctrl.sv
module i2c_tgt_addr_ctrl
  import i2c_tac_pkg::*;
#(
  parameter bit               DYN_UPDATE = 1'b1,
  parameter logic [TAR_W-1:0] RST_TAR    = 10'h055,
  parameter bit               RST_M10    = 1'b1,
  parameter int               REG_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wr_data,
  output logic [REG_W-1:0] reg_rd_data,
  input  logic             ctl_enabled,
  input  logic             mst_mode,
  input  logic             mst_busy,
  input  logic             txf_empty,
  output logic             wr_rejected,
  input  logic             cmd_valid,
  input  logic             cmd_is_read,
  input  logic             abort_clr,
  output logic             cmd_fwd,
  output logic             tx_abort,
  output logic [1:0]       addr_mode,
  output logic [7:0]       first_byte,
  output logic [7:0]       second_byte
);

  logic     wr_accept;
  logic     wr_drop;
  tgt_cfg_t cfg;
  amode_t   mode;
  logic     gc_mode;

  i2c_tac_wr_gate #(.DYN_UPDATE(DYN_UPDATE)) u_gate (
    .wr_en       (reg_wr_en),
    .ctl_enabled (ctl_enabled),
    .mst_mode    (mst_mode),
    .mst_busy    (mst_busy),
    .txf_empty   (txf_empty),
    .wr_accept   (wr_accept),
    .wr_drop     (wr_drop)
  );

  i2c_tac_regs #(
    .DYN_UPDATE (DYN_UPDATE),
    .RST_TAR    (RST_TAR),
    .RST_M10    (RST_M10),
    .REG_W      (REG_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_accept   (wr_accept),
    .wr_drop     (wr_drop),
    .wr_data     (reg_wr_data[CFG_W-1:0]),
    .cfg         (cfg),
    .rd_data     (reg_rd_data),
    .wr_rejected (wr_rejected)
  );

  i2c_tac_addr_phase u_phase (
    .cfg         (cfg),
    .cmd_is_read (cmd_is_read),
    .mode        (mode),
    .b_first     (first_byte),
    .b_second    (second_byte)
  );

  assign addr_mode = mode;
  assign gc_mode   = (mode == AM_GCALL);

  i2c_tac_abort u_abort (
    .clk         (clk),
    .rst_n       (rst_n),
    .gc_mode     (gc_mode),
    .cmd_valid   (cmd_valid),
    .cmd_is_read (cmd_is_read),
    .abort_clr   (abort_clr),
    .cmd_fwd     (cmd_fwd),
    .tx_abort    (tx_abort)
  );

  AST_HIGH_BITS_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && (|reg_wr_data[REG_W-1:CFG_W])) |=> (reg_rd_data[REG_W-1:CFG_W] == '0));  // R2
  AST_ENABLED_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && ctl_enabled && mst_busy) |=> wr_rejected);  // R4
  AST_DISABLED_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !ctl_enabled) |=> !wr_rejected);  // R3

endmodule

// File: tb/tb_i2c_tgt_addr_ctrl.sv
module tb_i2c_tgt_addr_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic        ctl_enabled = 1'b0, mst_mode = 1'b1, mst_busy = 1'b0, txf_empty = 1'b1;
  logic        wr_rejected;
  logic        cmd_valid = 1'b0, cmd_is_read = 1'b0, abort_clr = 1'b0;
  logic        cmd_fwd, tx_abort;
  logic [1:0]  addr_mode;
  logic [7:0]  first_byte, second_byte;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  i2c_tgt_addr_ctrl dut (.*);

  // behavioural reference state
  int m_tar, m_m10, m_spec, m_sel, m_abort, m_rej;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tar = 'h55; m_m10 = 1; m_spec = 0; m_sel = 0; m_abort = 0; m_rej = 0;
    end else begin
      bit ok;
      bit gc_now;
      gc_now = (m_spec == 1) && (m_sel == 0);
      ok = reg_wr_en && (!ctl_enabled || (!mst_busy && mst_mode && txf_empty));
      if (cmd_valid && cmd_is_read && gc_now) m_abort = 1;
      else if (abort_clr) m_abort = 0;
      m_rej = (reg_wr_en && !ok) ? 1 : 0;
      if (ok) begin
        m_tar  = reg_wr_data % 1024;
        m_sel  = (reg_wr_data / 1024) % 2;
        m_spec = (reg_wr_data / 2048) % 2;
        m_m10  = (reg_wr_data / 4096) % 2;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int e_mode, e_first, e_second, e_fwd, rd;
    rd = cmd_is_read ? 1 : 0;
    if (m_spec == 1) e_mode = (m_sel == 1) ? 3 : 2;
    else             e_mode = m_m10;
    case (e_mode)
      0: e_first = (m_tar % 128) * 2 + rd;
      1: e_first = 240 + (m_tar / 256) * 2 + rd;
      2: e_first = 0;
      default: e_first = 1;
    endcase
    e_second = (e_mode == 1) ? (m_tar % 256) : 0;
    e_fwd    = (cmd_valid && !(e_mode == 2 && rd == 1)) ? 1 : 0;
    chk("R1/R2/R3/R4 rd_data", reg_rd_data,
        m_m10 * 4096 + m_spec * 2048 + m_sel * 1024 + m_tar);
    chk("R5 wr_rejected", wr_rejected, m_rej);
    chk("R6/R8/R9 addr_mode", addr_mode, e_mode);
    chk("R6/R7/R8/R9 first_byte", first_byte, e_first);
    chk("R7 second_byte", second_byte, e_second);
    chk("R8/R10 cmd_fwd", cmd_fwd, e_fwd);
    chk("R10/R11 tx_abort", tx_abort, m_abort);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    reg_wr_en = 1'b0;
    abort_clr = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr_en = 1'b1; reg_wr_data = d;
    step();
  endtask

  task automatic cmd(input logic v, input logic r);
    cmd_valid = v; cmd_is_read = r;
    step();
  endtask

  task automatic status(input logic en, input logic mm, input logic bz, input logic te);
    ctl_enabled = en; mst_mode = mm; mst_busy = bz; txf_empty = te;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();                         // R1 reset state
    cmd(1'b1, 1'b1); cmd(1'b1, 1'b0);      // R6/R7 defaults in 10-bit mode

    // R3/R2: disabled write, high bits set, 7-bit address
    status(1'b0, 1'b0, 1'b1, 1'b0);
    wr(32'hFFFF_E3A5);
    cmd(1'b1, 1'b1); cmd(1'b1, 1'b0);
    // R7: 10-bit address with distinct upper bits
    wr(32'h0000_12F0);
    cmd(1'b1, 1'b1); cmd(1'b0, 1'b0);

    // R4/R5: every status combination while enabled
    for (int k = 0; k < 8; k++) begin
      status(1'b1, k[0], k[1], k[2]);
      wr(32'h0000_0100 + 32'(k));
      step();
    end

    // R8/R10/R11: general call
    status(1'b0, 1'b1, 1'b0, 1'b1);
    wr(32'h0000_0BFF);
    cmd(1'b1, 1'b0);
    cmd(1'b1, 1'b1);
    cmd(1'b0, 1'b0); cmd(1'b0, 1'b0);      // R10 sticky
    abort_clr = 1'b1; cmd(1'b1, 1'b1);     // R11 set wins over clear
    abort_clr = 1'b1; cmd(1'b0, 1'b0);     // R11 clear
    cmd(1'b0, 1'b0);
    // R9: START byte; reads do not abort
    wr(32'h0000_0C12);
    cmd(1'b1, 1'b1); cmd(1'b1, 1'b0);
    // R11: clearing bit 11 ends general call
    wr(32'h0000_0800); cmd(1'b1, 1'b1);
    abort_clr = 1'b1; wr(32'h0000_0077);
    cmd(1'b1, 1'b1); cmd(1'b1, 1'b0);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      status(r[0], r[1] | r[2], r[3] & r[4], r[5] | r[6]);
      cmd_valid = r[7]; cmd_is_read = r[8];
      abort_clr = (r[11:9] == 3'b000);
      reg_wr_en = (r[14:12] == 3'b000);
      reg_wr_data = $urandom;
      if (r[16:15] == 2'b00) reg_wr_data[11:10] = 2'b10;
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule